// File: doc/BRIEF.md
# Serial Receive Data Output Interface

This block sits between a receiver's demodulator and an external network processor. It hands each demodulated header or payload bit to the processor over three wires: a serial data line, a bit clock and an active-high frame envelope that marks the whole transfer.

While the receiver is acquiring, the bit clock and the envelope are held low. The demodulator reports that bit sync has been declared and that the signal-quality estimate has passed its thresholds. Once both are true, the envelope rises and every demodulated bit that follows appears on the data line, with one bit-clock pulse per bit. A frame closes when the demodulator reports end of data, when the link is lost, or when a bit-length limit loaded at frame start has been used up. The block then falls back to acquisition and needs a fresh sync declaration before it opens another frame. When the receive enable is low, the block stays in standby with all outputs low.

Top module: `rxo_serial_out`

## Requirements
- R1: While `rst` is high or `rx_en` is low, `rx_frame`, `rx_bclk` and `rx_data` are 0. They are 0 one cycle after `rx_en` is sampled low, and sync or quality strobes have no effect during standby.
- R2: During acquisition, `rx_bclk` and `rx_data` stay 0 whatever `bit_valid` and `bit_in` do. `rx_bclk` is never 1 while `rx_frame` is 0.
- R3: `rx_frame` rises one cycle after a cycle in which `qual_ok` is high and sync is declared. Sync counts as declared if `sync_ok` is high in that same cycle or was high earlier in the same acquisition. A `sync_ok` without `qual_ok`, or a `qual_ok` without a prior or same-cycle `sync_ok`, leaves `rx_frame` at 0.
- R4: A bit accepted in the frame (`bit_valid` high) appears on `rx_data` one cycle later with `rx_bclk` low. In the next cycle `rx_bclk` is high for exactly one cycle while `rx_data` holds the bit.
- R5: Bits leave in the order they arrive. The demodulator supplies each field least-significant bit first, so a field sent as bits 0..N-1 is read back with bit 0 on the first clock pulse.
- R6: A `bit_valid` that arrives in the cycle right after an accepted bit (the pulse cycle) is discarded. `rx_data` keeps the earlier bit and no extra pulse follows.
- R7: `len_bits` is loaded when `rx_frame` rises. After the `len_bits`-th clock pulse, `rx_frame` falls one cycle after that pulse, and `rx_data` returns to 0 at the same time. A `len_bits` of 0 sets no length limit.
- R8: `link_lost` or `data_end` sampled high during a frame drives `rx_frame`, `rx_bclk` and `rx_data` to 0 at the next edge. A bit strobe or a pending clock pulse in that cycle is dropped.
- R9: After a frame ends, the block is back in acquisition. Sync seen before or during the ended frame is forgotten, so a lone `qual_ok` does not reopen a frame.
- R10: `rx_data` is 0 whenever `rx_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low means standby |
| sync_ok | input | 1 | Strobe: bit sync declared |
| qual_ok | input | 1 | Strobe: signal quality passed thresholds |
| link_lost | input | 1 | Strobe: link interrupted |
| data_end | input | 1 | Strobe: no more receive data |
| bit_valid | input | 1 | Strobe: a demodulated bit is on bit_in |
| bit_in | input | 1 | Demodulated bit |
| len_bits | input | LEN_W | Frame length in bits, 0 = unlimited |
| rx_bclk | output | 1 | Receive bit clock |
| rx_data | output | 1 | Serial receive data |
| rx_frame | output | 1 | Data-ready envelope, active high |

## Verification
Two functions can fall in the same cycle. A bit strobe can coincide with a frame-ending strobe, and a new bit strobe can coincide with the clock pulse of the previous bit. The bench holds `link_lost` together with `bit_valid`, and `data_end` in the pulse cycle of a bit, then checks that the envelope, clock and data are all low at the next edge with no pulse. It also holds `bit_valid` for two consecutive cycles and checks that the second bit never reaches `rx_data`. A length sweep over every bit pattern of 1 to 5 bits compares the recovered word with the pattern and checks that the envelope falls one cycle after the last pulse.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ACQ   = 2'd1,
    ST_DATA  = 2'd2,
    ST_CLOSE = 2'd3
  } rxo_state_e;
endpackage

// File: rtl/rxo_ctrl.sv
module rxo_ctrl
  import rxo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       sync_ok,
  input  logic       qual_ok,
  input  logic       stop_req,
  input  logic       last_fire,
  output logic       run,
  output logic       start,
  output logic       frame_q
);
  rxo_state_e state, nxt;
  logic       sync_seen;
  logic       sync_now;

  assign sync_now = sync_seen | sync_ok;

  always_comb begin
    nxt = state;
    if (!rx_en) begin
      nxt = ST_OFF;
    end else begin
      case (state)
        ST_OFF:   nxt = ST_ACQ;
        ST_ACQ:   if (sync_now && qual_ok) nxt = ST_DATA;
        ST_DATA:  begin
          if (stop_req)       nxt = ST_ACQ;
          else if (last_fire) nxt = ST_CLOSE;
        end
        default:  nxt = ST_ACQ;
      endcase
    end
  end

  assign run   = rx_en && (state == ST_DATA) && !stop_req;
  assign start = (state == ST_ACQ) && (nxt == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      sync_seen <= 1'b0;
      frame_q   <= 1'b0;
    end else begin
      state     <= nxt;
      sync_seen <= (state == ST_ACQ) && (nxt == ST_ACQ) && sync_now;
      frame_q   <= (nxt == ST_DATA) || (nxt == ST_CLOSE);
    end
  end
endmodule

// File: rtl/rxo_len_cnt.sv
module rxo_len_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             dec,
  output logic             at_one
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  logic [LEN_W-1:0] cnt_q;

  assign at_one = (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len_in;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/rxo_bit_drive.sv
module rxo_bit_drive (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic at_one,
  output logic accept,
  output logic last_fire,
  output logic bclk_q,
  output logic data_q
);
  logic pend_q;
  logic last_q;

  assign accept    = run && !pend_q && bit_valid;
  assign last_fire = pend_q && last_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bclk_q <= 1'b0;
      data_q <= 1'b0;
      pend_q <= 1'b0;
      last_q <= 1'b0;
    end else if (pend_q) begin
      bclk_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (bit_valid) begin
      data_q <= bit_in;
      bclk_q <= 1'b0;
      pend_q <= 1'b1;
      last_q <= at_one;
    end else begin
      bclk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxo_serial_out.sv
module rxo_serial_out #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             sync_ok,
  input  logic             qual_ok,
  input  logic             link_lost,
  input  logic             data_end,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic [LEN_W-1:0] len_bits,
  output logic             rx_bclk,
  output logic             rx_data,
  output logic             rx_frame
);
  logic run, start, accept, last_fire, at_one, stop_req;

  assign stop_req = link_lost | data_end;

  rxo_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .sync_ok   (sync_ok),
    .qual_ok   (qual_ok),
    .stop_req  (stop_req),
    .last_fire (last_fire),
    .run       (run),
    .start     (start),
    .frame_q   (rx_frame)
  );

  rxo_len_cnt #(.LEN_W(LEN_W)) u_len (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .len_in (len_bits),
    .dec    (accept),
    .at_one (at_one)
  );

  rxo_bit_drive u_drv (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .at_one    (at_one),
    .accept    (accept),
    .last_fire (last_fire),
    .bclk_q    (rx_bclk),
    .data_q    (rx_data)
  );
endmodule

// File: rtl/rxo_serial_out_chk.sv
module rxo_serial_out_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             qual_ok,
  input logic             link_lost,
  input logic             data_end,
  input logic [LEN_W-1:0] len_bits,
  input logic             rx_bclk,
  input logic             rx_data,
  input logic             rx_frame
);
  logic [LEN_W:0]   pulses;
  logic [LEN_W-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst || !rx_frame) begin
      pulses <= '0;
      lim    <= len_bits;
    end else if (rx_bclk) begin
      pulses <= pulses + 1'b1;
    end
  end

  assert_standby_R1: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rx_frame && !rx_bclk && !rx_data));
  assert_clk_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    rx_bclk |-> rx_frame);
  assert_start_needs_quality_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_frame) |-> ($past(qual_ok) && $past(rx_en)));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rx_bclk |=> !rx_bclk);
  assert_data_setup_R4: assert property (@(posedge clk) disable iff (rst)
    rx_bclk |-> $stable(rx_data));
  assert_len_limit_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_frame && lim != '0) |-> (pulses <= {1'b0, lim}));
  assert_len_close_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_bclk && lim != '0 && (pulses + 1'b1) == {1'b0, lim}) |=> !rx_frame);
  assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_frame && (link_lost || data_end)) |=> (!rx_frame && !rx_bclk));
  assert_idle_data_R10: assert property (@(posedge clk) disable iff (rst)
    !rx_frame |-> !rx_data);
endmodule

bind rxo_serial_out rxo_serial_out_chk #(.LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .qual_ok   (qual_ok),
  .link_lost (link_lost),
  .data_end  (data_end),
  .len_bits  (len_bits),
  .rx_bclk   (rx_bclk),
  .rx_data   (rx_data),
  .rx_frame  (rx_frame)
);

// File: tb/rxo_serial_out_tb.sv
module rxo_serial_out_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1, rx_en = 1'b0, sync_ok = 1'b0, qual_ok = 1'b0;
  logic link_lost = 1'b0, data_end = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic [LW-1:0] len_bits = '0;
  logic rx_bclk, rx_data, rx_frame;
  int total = 0, bad = 0;
  bit done = 1'b0;

  rxo_serial_out #(.LEN_W(LW)) u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .sync_ok(sync_ok), .qual_ok(qual_ok),
    .link_lost(link_lost), .data_end(data_end), .bit_valid(bit_valid),
    .bit_in(bit_in), .len_bits(len_bits), .rx_bclk(rx_bclk), .rx_data(rx_data),
    .rx_frame(rx_frame)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outputs packed as {frame,bclk,data}
  task automatic chk_out(input string req, input int exp);
    int act;
    act = {29'd0, rx_frame, rx_bclk, rx_data};
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic acquire(input int len);
    len_bits = LW'(len);
    sync_ok = 1'b1;
    tick();
    sync_ok = 1'b0;
    tick();
    chk(rx_frame == 1'b0, "R3 sync alone", rx_frame, 0);
    qual_ok = 1'b1;
    tick();
    qual_ok = 1'b0;
    chk(rx_frame == 1'b1, "R3 sync then quality", rx_frame, 1);
  endtask

  task automatic send_bit(input bit b, output bit got);
    bit_valid = 1'b1;
    bit_in = b;
    tick();
    bit_valid = 1'b0;
    chk(rx_data == b && rx_bclk == 1'b0, "R4 data before clock", {rx_bclk, rx_data}, {1'b0, b});
    tick();
    got = rx_data;
    chk(rx_bclk == 1'b1, "R4 clock pulse", rx_bclk, 1);
  endtask

  initial begin
    bit g;
    int word;
    chk_out("R1 in reset", 0);
    tick(); tick();
    rst = 1'b0;
    tick();
    sync_ok = 1'b1; qual_ok = 1'b1;
    tick(); tick();
    chk_out("R1 standby ignores strobes", 0);
    sync_ok = 1'b0; qual_ok = 1'b0;
    rx_en = 1'b1;
    tick();
    // R2: bits during acquisition produce nothing
    for (int i = 0; i < 4; i++) begin
      bit_valid = 1'b1; bit_in = 1'b1;
      tick();
      chk_out("R2 acquisition idle", 0);
    end
    bit_valid = 1'b0; bit_in = 1'b0;
    qual_ok = 1'b1;
    tick();
    qual_ok = 1'b0;
    chk(rx_frame == 1'b0, "R3 quality alone", rx_frame, 0);

    // R5/R7 sweep: every pattern of 1..5 bits
    for (int len = 1; len <= 5; len++) begin
      for (int p = 0; p < (1 << len); p++) begin
        acquire(len);
        word = 0;
        for (int i = 0; i < len; i++) begin
          send_bit(p[i], g);
          word |= int'(g) << i;
        end
        chk(rx_frame == 1'b1, "R7 envelope covers last pulse", rx_frame, 1);
        tick();
        chk_out("R7 R10 frame closes after last pulse", 0);
        chk(word == p, "R5 lsb-first order", word, p);
      end
    end

    // R9: lone quality after a closed frame does nothing
    qual_ok = 1'b1;
    tick();
    qual_ok = 1'b0;
    chk(rx_frame == 1'b0, "R9 sync forgotten", rx_frame, 0);
    // R3: sync and quality in the same cycle
    sync_ok = 1'b1; qual_ok = 1'b1; len_bits = '0;
    tick();
    sync_ok = 1'b0; qual_ok = 1'b0;
    chk(rx_frame == 1'b1, "R3 same-cycle start", rx_frame, 1);

    // R7: length 0 is unlimited
    for (int i = 0; i < 20; i++) send_bit(i[0], g);
    tick();
    chk(rx_frame == 1'b1, "R7 unlimited length", rx_frame, 1);

    // R6: back-to-back strobe discarded
    bit_valid = 1'b1; bit_in = 1'b1;
    tick();
    bit_in = 1'b0;
    tick();
    bit_valid = 1'b0;
    chk(rx_bclk == 1'b1 && rx_data == 1'b1, "R6 pulse keeps first bit", {rx_bclk, rx_data}, 3);
    tick();
    chk(rx_bclk == 1'b0 && rx_data == 1'b1, "R6 second strobe dropped", {rx_bclk, rx_data}, 1);

    // R8: link lost together with a bit
    link_lost = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    tick();
    link_lost = 1'b0; bit_valid = 1'b0;
    chk_out("R8 link lost", 0);
    tick();
    chk_out("R8 stays closed", 0);

    // R8: end of data during a pending pulse
    acquire(0);
    bit_valid = 1'b1; bit_in = 1'b1;
    tick();
    bit_valid = 1'b0; data_end = 1'b1;
    tick();
    data_end = 1'b0;
    chk_out("R8 end of data drops pulse", 0);

    // R1: enable dropped mid-frame
    acquire(0);
    bit_valid = 1'b1; bit_in = 1'b1;
    tick();
    bit_valid = 1'b0; rx_en = 1'b0;
    tick();
    chk_out("R1 enable low mid-frame", 0);
    rx_en = 1'b1;
    tick();
    sync_ok = 1'b1; qual_ok = 1'b1;
    tick();
    sync_ok = 1'b0; qual_ok = 1'b0;
    chk(rx_frame == 1'b1, "R1 resumes after enable", rx_frame, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule